// File: doc/BRIEF.md
# Word-Stream Register Access Command Engine

This block sits between a mailbox that delivers 32-bit words and a simple internal register bus with 64-bit data. Each request in the incoming stream sizes itself: its first word gives the total number of words it contains. The engine consumes exactly that many words, decodes a register-access command, and checks it. It then runs a get, put, modify or put-under-mask operation on the register bus. Afterwards it emits a framed stream of 32-bit response words.

A response carries the following words, in order:
- the read data, for a get that succeeded;
- a two-word status header that starts with a fixed magic value;
- one bus error word, only when the bus reported a failure;
- a distance word that points back to the start of the header;
- a fixed end word.

Requests are handled strictly one at a time. The input stays closed from the moment a request is complete until the end word of its response has been taken.

Top module: `rae_engine`

## Requirements
- R1: Word 0 of a request is the word count N. Bits [15:8] of word 1 are the command class and bits [7:0] are the command code. Bits [31:16] of word 1 are ignored. The engine consumes exactly max(N,1) words, and the next request starts with the following word.
- R2: The accepted class is 0xA2. Command 0x01 is get (N=4), 0x02 is put (N=6), 0x03 is modify (N=6) and 0x04 is put-under-mask (N=8). Words 2-3 are the address, words 4-5 the data and words 6-7 the mask. Each 64-bit value is sent upper half (bits 63:32) first.
- R3: A get reads the address. If the read succeeds, the response begins with the read data, upper word first.
- R4: A put writes the data. Modify reads the old value and writes old | data. Put-under-mask reads the old value and writes (old & ~mask) | (data & mask). Both read-then-write operations use the same address.
- R5: Header word 0 is {16'hC0DE, class, command}, echoing the received class and command; both are 0 when N<2. Header word 1 is {primary[15:0], secondary[15:0]}, and success is 0/0.
- R6: Checks apply in this priority order:
  - N<2 gives 0x02/0x0E.
  - A class other than 0xA2 gives 0x01/0x01.
  - An unknown command gives 0x01/0x02.
  - N below the expected count gives 0x02/0x0E.
  - N above the expected count gives 0x02/0x0F.
  In all of these cases no bus access takes place and no error word is sent.
- R7: A nonzero bus status on a completed access yields primary 0xFE and secondary 0x0A. The bus status word then follows the header. No further bus access is made, and a failed get returns no data.
- R8: The distance word is 3 without an error word and 4 with one. It is followed by the end word 0x00000000.
- R9: bus_req stays high, with address, direction and write data stable, until bus_ready. bus_req is never high while the input is open.
- R10: out_data and out_valid hold while out_ready is low. in_ready and out_valid are never high together.
- R11: After reset, in_ready is 1 and out_valid and bus_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request word present |
| in_data | input | WORD_W | Request word |
| in_ready | output | 1 | Engine accepts a request word |
| out_valid | output | 1 | Response word present |
| out_data | output | WORD_W | Response word |
| out_ready | input | 1 | Sink takes the response word |
| bus_req | output | 1 | Register bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | REG_W | Register address |
| bus_wdata | output | REG_W | Write data |
| bus_ready | input | 1 | Access complete this cycle |
| bus_rdata | input | REG_W | Read data, valid with bus_ready |
| bus_status | input | WORD_W | Access status, nonzero means failure |

## Verification
The bench builds the engine with its default parameters: 32-bit words, 64-bit registers, class code 0xA2 and magic 0xC0DE. These values let the bench drive the real request layout. The bench bus model makes addresses with top byte 0xEE fail on every access, and addresses with top byte 0xEF fail only on writes. This reaches read failures as well as a put-under-mask whose read succeeds but whose write fails. Word counts of 0, 1, 2, 3, 5, 8 and 9 are sent next to correct ones. Together they reach every branch of the check priority and the discarding of excess words, all under input gaps, output stalls and bus latencies of up to three cycles.

// File: rtl/rae_pkg.sv
package rae_pkg;
   localparam logic [7:0] CMD_GET = 8'h01;
   localparam logic [7:0] CMD_PUT = 8'h02;
   localparam logic [7:0] CMD_MOD = 8'h03;
   localparam logic [7:0] CMD_PUM = 8'h04;

   localparam logic [7:0] PRI_OK       = 8'h00;
   localparam logic [7:0] PRI_BAD_CMD  = 8'h01;
   localparam logic [7:0] PRI_BAD_DATA = 8'h02;
   localparam logic [7:0] PRI_FAIL     = 8'hFE;

   localparam logic [7:0] SEC_OK       = 8'h00;
   localparam logic [7:0] SEC_CLASS_NS = 8'h01;
   localparam logic [7:0] SEC_CMD_NS   = 8'h02;
   localparam logic [7:0] SEC_EXEC_ERR = 8'h0A;
   localparam logic [7:0] SEC_SHORT    = 8'h0E;
   localparam logic [7:0] SEC_LONG     = 8'h0F;

   typedef struct packed {
      logic [7:0]  cls;
      logic [7:0]  cmd;
      logic [63:0] addr;
      logic [63:0] data;
      logic [63:0] mask;
      logic [7:0]  pri;
      logic [7:0]  sec;
   } req_t;

   typedef struct packed {
      logic [7:0]  cls;
      logic [7:0]  cmd;
      logic [7:0]  pri;
      logic [7:0]  sec;
      logic [31:0] err_word;
      logic [63:0] rdata;
      logic        has_data;
      logic        has_err;
   } rsp_t;
endpackage

// File: rtl/rae_rx.sv
module rae_rx
   import rae_pkg::*;
#(
   parameter logic [7:0] CLASS_CODE = 8'hA2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [31:0] in_data,
   output logic        in_ready,
   input  logic        release_i,
   output logic        req_valid,
   output req_t        req
);
   logic        busy;
   logic [31:0] idx, cnt;
   logic [7:0]  cls_q, cmd_q;
   logic [63:0] addr_q, data_q, mask_q;
   logic        last;
   logic [31:0] exp_len;

   assign in_ready  = !busy;
   assign req_valid = busy;
   assign last      = (idx == 32'd0) ? (in_data <= 32'd1) : (idx == cnt - 32'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         cnt    <= '0;
         cls_q  <= '0;
         cmd_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
         mask_q <= '0;
      end else if (busy) begin
         if (release_i) busy <= 1'b0;
      end else if (in_valid) begin
         case (idx)
            32'd0: begin
               cnt   <= in_data;
               cls_q <= '0;
               cmd_q <= '0;
            end
            32'd1: begin
               cls_q <= in_data[15:8];
               cmd_q <= in_data[7:0];
            end
            32'd2: addr_q[63:32] <= in_data;
            32'd3: addr_q[31:0]  <= in_data;
            32'd4: data_q[63:32] <= in_data;
            32'd5: data_q[31:0]  <= in_data;
            32'd6: mask_q[63:32] <= in_data;
            32'd7: mask_q[31:0]  <= in_data;
            default: ;
         endcase
         if (last) begin
            idx  <= '0;
            busy <= 1'b1;
         end else begin
            idx <= idx + 32'd1;
         end
      end
   end

   always_comb begin
      case (cmd_q)
         CMD_GET:          exp_len = 32'd4;
         CMD_PUT, CMD_MOD: exp_len = 32'd6;
         CMD_PUM:          exp_len = 32'd8;
         default:          exp_len = 32'd0;
      endcase
      req.cls  = cls_q;
      req.cmd  = cmd_q;
      req.addr = addr_q;
      req.data = data_q;
      req.mask = mask_q;
      if (cnt < 32'd2) begin
         req.pri = PRI_BAD_DATA; req.sec = SEC_SHORT;
      end else if (cls_q != CLASS_CODE) begin
         req.pri = PRI_BAD_CMD;  req.sec = SEC_CLASS_NS;
      end else if (exp_len == 32'd0) begin
         req.pri = PRI_BAD_CMD;  req.sec = SEC_CMD_NS;
      end else if (cnt < exp_len) begin
         req.pri = PRI_BAD_DATA; req.sec = SEC_SHORT;
      end else if (cnt > exp_len) begin
         req.pri = PRI_BAD_DATA; req.sec = SEC_LONG;
      end else begin
         req.pri = PRI_OK;       req.sec = SEC_OK;
      end
   end
endmodule

// File: rtl/rae_exec.sv
module rae_exec
   import rae_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  req_t        req,
   input  logic        release_i,
   output logic        bus_req,
   output logic        bus_we,
   output logic [63:0] bus_addr,
   output logic [63:0] bus_wdata,
   input  logic        bus_ready,
   input  logic [63:0] bus_rdata,
   input  logic [31:0] bus_status,
   output logic        res_valid,
   output rsp_t        rsp
);
   typedef enum logic [1:0] {EX_IDLE, EX_RD, EX_WR, EX_DONE} ex_state_t;
   ex_state_t   st;
   logic [63:0] rdata_q, wdata_q, merged;
   logic [31:0] status_q;
   logic        failed;

   assign merged = (req.cmd == CMD_MOD) ? (bus_rdata | req.data)
                                        : ((bus_rdata & ~req.mask) | (req.data & req.mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= EX_IDLE;
         rdata_q  <= '0;
         wdata_q  <= '0;
         status_q <= '0;
         failed   <= 1'b0;
      end else begin
         case (st)
            EX_IDLE: if (req_valid) begin
               failed   <= 1'b0;
               status_q <= '0;
               rdata_q  <= '0;
               wdata_q  <= req.data;
               if (req.pri != PRI_OK)       st <= EX_DONE;
               else if (req.cmd == CMD_PUT) st <= EX_WR;
               else                         st <= EX_RD;
            end
            EX_RD: if (bus_ready) begin
               rdata_q <= bus_rdata;
               if (bus_status != '0) begin
                  failed   <= 1'b1;
                  status_q <= bus_status;
                  st       <= EX_DONE;
               end else if (req.cmd == CMD_GET) begin
                  st <= EX_DONE;
               end else begin
                  wdata_q <= merged;
                  st      <= EX_WR;
               end
            end
            EX_WR: if (bus_ready) begin
               if (bus_status != '0) begin
                  failed   <= 1'b1;
                  status_q <= bus_status;
               end
               st <= EX_DONE;
            end
            EX_DONE: if (release_i) st <= EX_IDLE;
            default: st <= EX_IDLE;
         endcase
      end
   end

   assign bus_req   = (st == EX_RD) || (st == EX_WR);
   assign bus_we    = (st == EX_WR);
   assign bus_addr  = req.addr;
   assign bus_wdata = wdata_q;
   assign res_valid = (st == EX_DONE);

   always_comb begin
      rsp.cls      = req.cls;
      rsp.cmd      = req.cmd;
      rsp.pri      = failed ? PRI_FAIL : req.pri;
      rsp.sec      = failed ? SEC_EXEC_ERR : req.sec;
      rsp.err_word = status_q;
      rsp.rdata    = rdata_q;
      rsp.has_err  = failed;
      rsp.has_data = !failed && (req.pri == PRI_OK) && (req.cmd == CMD_GET);
   end
endmodule

// File: rtl/rae_tx.sv
module rae_tx
   import rae_pkg::*;
#(
   parameter logic [15:0] MAGIC    = 16'hC0DE,
   parameter logic [31:0] END_WORD = 32'h0000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        res_valid,
   input  rsp_t        rsp,
   output logic        out_valid,
   output logic [31:0] out_data,
   input  logic        out_ready,
   output logic        release_o
);
   typedef enum logic [2:0] {TX_IDLE, TX_DHI, TX_DLO, TX_H0, TX_H1, TX_ERR, TX_DIST, TX_END} tx_state_t;
   tx_state_t st;
   logic      take;

   assign out_valid = (st != TX_IDLE);
   assign take      = out_valid && out_ready;
   assign release_o = take && (st == TX_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= TX_IDLE;
      end else if (st == TX_IDLE) begin
         if (res_valid) st <= rsp.has_data ? TX_DHI : TX_H0;
      end else if (take) begin
         case (st)
            TX_DHI:  st <= TX_DLO;
            TX_DLO:  st <= TX_H0;
            TX_H0:   st <= TX_H1;
            TX_H1:   st <= rsp.has_err ? TX_ERR : TX_DIST;
            TX_ERR:  st <= TX_DIST;
            TX_DIST: st <= TX_END;
            default: st <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         TX_DHI:  out_data = rsp.rdata[63:32];
         TX_DLO:  out_data = rsp.rdata[31:0];
         TX_H0:   out_data = {MAGIC, rsp.cls, rsp.cmd};
         TX_H1:   out_data = {8'h00, rsp.pri, 8'h00, rsp.sec};
         TX_ERR:  out_data = rsp.err_word;
         TX_DIST: out_data = rsp.has_err ? 32'd4 : 32'd3;
         TX_END:  out_data = END_WORD;
         default: out_data = '0;
      endcase
   end
endmodule

// File: rtl/rae_engine.sv
module rae_engine
   import rae_pkg::*;
#(
   parameter int          WORD_W     = 32,
   parameter int          REG_W      = 64,
   parameter logic [7:0]  CLASS_CODE = 8'hA2,
   parameter logic [15:0] MAGIC      = 16'hC0DE,
   parameter logic [31:0] END_WORD   = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   input  logic              out_ready,
   output logic              bus_req,
   output logic              bus_we,
   output logic [REG_W-1:0]  bus_addr,
   output logic [REG_W-1:0]  bus_wdata,
   input  logic              bus_ready,
   input  logic [REG_W-1:0]  bus_rdata,
   input  logic [WORD_W-1:0] bus_status
);
   if (WORD_W != 32) begin : g_word_chk
      $error("WORD_W must be 32");
   end
   if (REG_W != 2 * WORD_W) begin : g_reg_chk
      $error("REG_W must be twice WORD_W");
   end
   if (CLASS_CODE == 8'h00) begin : g_cls_chk
      $error("CLASS_CODE 0 is reserved for an absent class field");
   end

   req_t req;
   rsp_t rsp;
   logic req_valid, res_valid, release_s;

   rae_rx #(.CLASS_CODE(CLASS_CODE)) u_rx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .release_i(release_s), .req_valid(req_valid), .req(req)
   );

   rae_exec u_exec (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req), .release_i(release_s),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_status(bus_status),
      .res_valid(res_valid), .rsp(rsp)
   );

   rae_tx #(.MAGIC(MAGIC), .END_WORD(END_WORD)) u_tx (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .rsp(rsp),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .release_o(release_s)
   );
endmodule

// File: rtl/rae_engine_chk.sv
module rae_engine_chk #(
   parameter int WORD_W = 32,
   parameter int REG_W  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_data,
   input logic              out_ready,
   input logic              bus_req,
   input logic              bus_we,
   input logic [REG_W-1:0]  bus_addr,
   input logic [REG_W-1:0]  bus_wdata,
   input logic              bus_ready,
   input logic [WORD_W-1:0] bus_status
);
   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R10
   in_out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   // R9
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

   // R9
   bus_closed_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !bus_req);

   // R7
   no_access_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ready && (bus_status != '0)) |=> !bus_req);

   // R11
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (in_ready && !out_valid && !bus_req));
endmodule

bind rae_engine rae_engine_chk #(.WORD_W(WORD_W), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
   .out_data(out_data), .out_ready(out_ready), .bus_req(bus_req), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
   .bus_status(bus_status)
);

// File: tb/tb_rae_engine.sv
module tb_rae_engine;
   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_ready = 1'b0;
   logic        bus_req, bus_we;
   logic [63:0] bus_addr, bus_wdata;
   logic        bus_ready = 1'b0;
   logic [63:0] bus_rdata = '0;
   logic [31:0] bus_status = '0;

   rae_engine dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_status(bus_status)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   int          txn = 0;
   int          wait_left = -1;
   bit          running = 0;
   bit          in_took = 0;
   logic [31:0] in_q[$];
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        xb_we[$];
   logic [63:0] xb_addr[$];
   logic [63:0] xb_wdata[$];
   logic [31:0] cur[$];
   logic [63:0] ref_mem[logic [63:0]];
   logic [63:0] bus_mem[logic [63:0]];

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [63:0] init_val(input logic [63:0] a);
      return a ^ 64'h0123_4567_89AB_CDEF;
   endfunction
   function automatic bit rd_err(input logic [63:0] a);
      return a[63:56] == 8'hEE;
   endfunction
   function automatic bit wr_err(input logic [63:0] a);
      return (a[63:56] == 8'hEE) || (a[63:56] == 8'hEF);
   endfunction
   function automatic logic [31:0] err_code(input logic [63:0] a);
      return 32'h5A00_0000 | {16'h0, a[15:0]};
   endfunction

   task automatic push_exp(input logic [31:0] w, input string t);
      exp_q.push_back(w);
      tag_q.push_back(t);
   endtask
   task automatic push_bus(input logic we, input logic [63:0] a, input logic [63:0] d);
      xb_we.push_back(we);
      xb_addr.push_back(a);
      xb_wdata.push_back(d);
   endtask

   // Reference model: one request from cur[], expected response and bus traffic
   task automatic issue(input string dtag);
      logic [31:0] n, elen;
      logic [7:0]  cls, cmd, pri, sec;
      logic [63:0] a, d, m, old, nv;
      logic [31:0] ew;
      bit          fail, has_d;
      n = cur[0];
      cls = 8'h00; cmd = 8'h00; fail = 0; has_d = 0; ew = 0; old = 0;
      if (n >= 2) begin cls = cur[1][15:8]; cmd = cur[1][7:0]; end
      elen = (cmd == 8'h01) ? 4 : (cmd == 8'h02 || cmd == 8'h03) ? 6 : (cmd == 8'h04) ? 8 : 0;
      if (n < 2)               begin pri = 8'h02; sec = 8'h0E; end
      else if (cls != 8'hA2)   begin pri = 8'h01; sec = 8'h01; end
      else if (elen == 0)      begin pri = 8'h01; sec = 8'h02; end
      else if (n < elen)       begin pri = 8'h02; sec = 8'h0E; end
      else if (n > elen)       begin pri = 8'h02; sec = 8'h0F; end
      else                     begin pri = 8'h00; sec = 8'h00; end
      if (pri == 8'h00) begin
         a = {cur[2], cur[3]};
         d = (n >= 6) ? {cur[4], cur[5]} : 64'h0;
         m = (n >= 8) ? {cur[6], cur[7]} : 64'h0;
         if (cmd != 8'h02) begin
            push_bus(1'b0, a, 64'h0);
            if (rd_err(a)) begin fail = 1; ew = err_code(a); end
            else old = ref_mem.exists(a) ? ref_mem[a] : init_val(a);
         end
         if (!fail && cmd == 8'h01) has_d = 1;
         if (!fail && cmd != 8'h01) begin
            nv = (cmd == 8'h02) ? d : (cmd == 8'h03) ? (old | d) : ((old & ~m) | (d & m));
            push_bus(1'b1, a, nv);
            if (wr_err(a)) begin fail = 1; ew = err_code(a); end
            else ref_mem[a] = nv;
         end
         if (fail) begin pri = 8'hFE; sec = 8'h0A; end
      end
      if (has_d) begin
         push_exp(old[63:32], dtag);
         push_exp(old[31:0], dtag);
      end
      push_exp({16'hC0DE, cls, cmd}, "R5");
      push_exp({8'h00, pri, 8'h00, sec}, fail ? "R7" : (pri == 0) ? "R2" : "R6");
      if (fail) push_exp(ew, "R7");
      push_exp(fail ? 32'd4 : 32'd3, "R8");
      push_exp(32'h0, "R8");
      foreach (cur[i]) in_q.push_back(cur[i]);
   endtask

   always @(negedge clk) begin
      if (running) begin
         cyc++;
         // input side
         if (in_took) void'(in_q.pop_front());
         in_valid = (in_q.size() > 0) && (cyc % 7 != 5);
         in_data  = (in_q.size() > 0) ? in_q[0] : 32'h0;
         in_took  = in_valid && in_ready;
         // output side
         out_ready = (cyc % 5 != 3);
         chk(!(in_ready && out_valid), "R10", "in_ready with out_valid", {63'h0, out_valid}, 64'h0);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(0, "R8", "unexpected response word", {32'h0, out_data}, 64'h0);
            end else begin
               chk(out_data == exp_q[0], tag_q[0], "response word", {32'h0, out_data}, {32'h0, exp_q[0]});
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
            end
         end
         // bus responder
         if (bus_ready) begin
            bus_ready = 0;
            wait_left = -1;
         end else if (bus_req) begin
            if (wait_left < 0) wait_left = txn % 3;
            if (wait_left == 0) begin
               if (xb_we.size() == 0) begin
                  chk(0, "R6", "unexpected bus access", bus_addr, 64'h0);
               end else begin
                  chk(bus_we == xb_we[0], "R4", "bus direction", {63'h0, bus_we}, {63'h0, xb_we[0]});
                  chk(bus_addr == xb_addr[0], "R9", "bus address", bus_addr, xb_addr[0]);
                  if (bus_we)
                     chk(bus_wdata == xb_wdata[0], "R4", "bus write data", bus_wdata, xb_wdata[0]);
                  void'(xb_we.pop_front());
                  void'(xb_addr.pop_front());
                  void'(xb_wdata.pop_front());
               end
               if (bus_we) begin
                  bus_status = wr_err(bus_addr) ? err_code(bus_addr) : 32'h0;
                  bus_rdata  = 64'h0;
                  if (!wr_err(bus_addr)) bus_mem[bus_addr] = bus_wdata;
               end else begin
                  bus_status = rd_err(bus_addr) ? err_code(bus_addr) : 32'h0;
                  bus_rdata  = bus_mem.exists(bus_addr) ? bus_mem[bus_addr] : init_val(bus_addr);
               end
               bus_ready = 1;
               txn++;
            end else begin
               wait_left--;
            end
         end
      end
   end

   initial begin
      // R3 plain get; R4 put/modify/mask then readback
      cur = '{32'd4, 32'h0000_A201, 32'h0, 32'h10};                                   issue("R3");
      cur = '{32'd6, 32'h0000_A202, 32'h0, 32'h20, 32'h1111_0000, 32'h0000_00F0};     issue("R3");
      cur = '{32'd4, 32'h0000_A201, 32'h0, 32'h20};                                   issue("R4");
      cur = '{32'd6, 32'h0000_A203, 32'h0, 32'h20, 32'h0000_0001, 32'h8000_0000};     issue("R3");
      cur = '{32'd4, 32'h0000_A201, 32'h0, 32'h20};                                   issue("R4");
      cur = '{32'd8, 32'h0000_A204, 32'h0, 32'h20, 32'hABCD_ABCD, 32'h1234_5678,
              32'hFFFF_0000, 32'h0F0F_0F0F};                                          issue("R3");
      cur = '{32'd4, 32'h0000_A201, 32'h0, 32'h20};                                   issue("R4");
      cur = '{32'd8, 32'h0000_A204, 32'h1, 32'h30, 32'hFFFF_FFFF, 32'h0,
              32'h00FF_00FF, 32'hFFFF_FFFF};                                          issue("R3");
      cur = '{32'd4, 32'h0000_A201, 32'h1, 32'h30};                                   issue("R4");
      // R1 reserved bits of word 1 ignored
      cur = '{32'd4, 32'hBEEF_A201, 32'h0, 32'h10};                                   issue("R1");
      // R7 bus failures
      cur = '{32'd4, 32'h0000_A201, 32'hEE00_0000, 32'h44};                           issue("R7");
      cur = '{32'd8, 32'h0000_A204, 32'hEF00_0000, 32'h55, 32'h1, 32'h2, 32'h3, 32'h4}; issue("R7");
      cur = '{32'd6, 32'h0000_A202, 32'hEE00_0000, 32'h66, 32'h1, 32'h2};             issue("R7");
      cur = '{32'd6, 32'h0000_A203, 32'hEE00_0000, 32'h67, 32'h1, 32'h2};             issue("R7");
      // R6 check priority and length handling
      cur = '{32'd4, 32'h0000_A301, 32'h0, 32'h10};                                   issue("R6");
      cur = '{32'd4, 32'h0000_A205, 32'h0, 32'h10};                                   issue("R6");
      cur = '{32'd4, 32'h0000_A200, 32'h0, 32'h10};                                   issue("R6");
      cur = '{32'd3, 32'h0000_A201, 32'h0};                                           issue("R6");
      cur = '{32'd5, 32'h0000_A201, 32'h0, 32'h10, 32'h7};                            issue("R6");
      cur = '{32'd9, 32'h0000_A204, 32'h0, 32'h20, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5}; issue("R6");
      cur = '{32'd8, 32'h0000_A202, 32'h0, 32'h20, 32'h1, 32'h2, 32'h3, 32'h4};       issue("R6");
      cur = '{32'd0};                                                                 issue("R6");
      cur = '{32'd1};                                                                 issue("R6");
      cur = '{32'd2, 32'h0000_A201};                                                  issue("R6");
      cur = '{32'd3, 32'h0000_A301, 32'h0};                                           issue("R6");
      // R1 the stream keeps its alignment after all of the above
      cur = '{32'd4, 32'h0000_A201, 32'h0, 32'h20};                                   issue("R1");

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      running = 1;
      @(negedge clk);
      #1;
      chk(in_ready == 1'b1, "R11", "in_ready after reset", {63'h0, in_ready}, 64'h1);
      chk(out_valid == 1'b0, "R11", "out_valid after reset", {63'h0, out_valid}, 64'h0);
      chk(bus_req == 1'b0, "R11", "bus_req after reset", {63'h0, bus_req}, 64'h0);

      while (!(in_q.size() == 0 && !in_took && exp_q.size() == 0 && in_ready) && cyc < LIMIT)
         @(negedge clk);
      if (cyc >= LIMIT) chk(0, "R10", "watchdog expired", 64'(cyc), 64'(LIMIT));
      repeat (5) @(negedge clk);
      chk(in_q.size() == 0, "R1", "request words left unconsumed", 64'(in_q.size()), 64'h0);
      chk(exp_q.size() == 0, "R8", "response words missing", 64'(exp_q.size()), 64'h0);
      chk(xb_we.size() == 0, "R4", "bus accesses missing", 64'(xb_we.size()), 64'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule